// File: doc/BRIEF.md
# Luma Noise Coring and Sharpening Unit

This unit takes an 8-bit luma stream together with a signed high-frequency detail sample for each pixel. An external band filter outside the unit produces that detail sample. The unit compares the magnitude of the detail against a programmable threshold and corrects the pixel in one of two ways. In noise mode it treats small detail as noise and removes a scaled copy of it. In sharpness mode it treats large detail as real picture content and adds a scaled copy of it. Two gains are available. A border gain applies to pixels that an external generator flags as block-border pixels, and a data gain applies to every other pixel.

A new pixel arrives at most every other clock and is marked by a strobe. Two 8-bit configuration words hold the threshold and the mode. They also carry fields that the neighbouring filter and border logic need, and the unit decodes those fields and passes them out to that logic. Each result is clamped to the 8-bit range and registered. A valid pulse marks the result.

Top module: `luma_coring_sharpen`

## Requirements
- R1: The threshold is `cfg_a[5:0]` (0 to 63), compared with the absolute value of the two's-complement `detail_in`. A magnitude equal to the threshold qualifies in neither mode, so the pixel passes unchanged.
- R2: In noise mode (`cfg_b[3]`=0), a detail whose magnitude is below the threshold gives `luma_out = luma_in - floor(detail*g/8)`, where g is the selected 4-bit gain code. The floor is an arithmetic right shift.
- R3: In sharpness mode (`cfg_b[3]`=1), a detail whose magnitude is above the threshold gives `luma_out = luma_in + floor(detail*g/16)`. Gain codes above 8 act as 8, which caps the gain at 0.5.
- R4: A detail that does not qualify under the current mode leaves the pixel unchanged. This includes the most negative detail value, -256.
- R5: When `border_in` is 1 the gain code is `border_gain`; when it is 0 the gain code is `data_gain`. A selected code of 0 leaves the pixel unchanged.
- R6: The result is clamped to the range 0 to 255.
- R7: A sample is taken on a clock edge where `pix_en` is 1. Its result appears on `luma_out` after that edge, and `out_valid` is 1 for exactly the one following cycle. While `pix_en` is 0, `out_valid` is 0 and `luma_out` holds its value.
- R8: During reset (`rst_n`=0), `luma_out` is 0 and `out_valid` is 0.
- R9: The unit decodes and passes out the neighbour fields: `flt_sel`=`cfg_b[2:0]`, `blk_offset`=`cfg_b[7:4]`, `border_wide`=`cfg_a[6]`, `blk_large`=`cfg_a[7]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_en | input | 1 | Strobe marking a new pixel sample |
| luma_in | input | 8 | Input luma sample |
| detail_in | input | 9 | Signed detail from the external band filter |
| border_in | input | 1 | 1 selects the border gain for this pixel |
| cfg_a | input | 8 | Threshold [5:0], border width [6], block size [7] |
| cfg_b | input | 8 | Filter select [2:0], mode [3], block offset [7:4] |
| border_gain | input | 4 | Gain code used on border pixels |
| data_gain | input | 4 | Gain code used on interior pixels |
| luma_out | output | 8 | Corrected, clamped luma |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| flt_sel | output | 3 | Band filter select for the external filter |
| blk_offset | output | 4 | Block offset for the external border generator |
| border_wide | output | 1 | Border width select for the border generator |
| blk_large | output | 1 | Block size select for the border generator |

## Verification
The gain selection and the clamp can act on the same pixel. A border pixel with a large gain can push the sum past 0 or 255 in the same cycle that the gain is chosen. The vectors include border and interior pixels whose products run out of range in both directions, and the bench compares each result with a hand-computed clamped value. The bench also puts a tie with the threshold next to qualifying magnitudes in both modes, and it checks that the held output does not change between strobes.

// File: rtl/luma_coring_sharpen.sv
module luma_coring_sharpen #(
  parameter int PW = 8,
  parameter int DW = 9,
  parameter int GW = 4,
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic [PW-1:0] luma_in,
  input  logic [DW-1:0] detail_in,
  input  logic          border_in,
  input  logic [7:0]    cfg_a,
  input  logic [7:0]    cfg_b,
  input  logic [GW-1:0] border_gain,
  input  logic [GW-1:0] data_gain,
  output logic [PW-1:0] luma_out,
  output logic          out_valid,
  output logic [2:0]    flt_sel,
  output logic [3:0]    blk_offset,
  output logic          border_wide,
  output logic          blk_large
);
  localparam int MW = DW + 1;
  localparam int XW = DW + GW + 3;
  localparam logic [GW-1:0] GCAP = GW'(1 << (GW - 1));
  localparam logic signed [XW-1:0] YMAX = XW'((1 << PW) - 1);

  logic                 sharp;
  logic signed [MW-1:0] det_x;
  logic [MW-1:0]        mag, thr;
  logic [GW-1:0]        g_sel, g_eff;
  logic signed [XW-1:0] prod, corr, delta, sum;
  logic                 qual;
  logic [PW-1:0]        y_next;

  assign sharp       = cfg_b[3];
  assign flt_sel     = cfg_b[2:0];
  assign blk_offset  = cfg_b[7:4];
  assign border_wide = cfg_a[6];
  assign blk_large   = cfg_a[7];

  assign det_x = {detail_in[DW-1], detail_in};
  assign mag   = det_x[MW-1] ? MW'(-det_x) : MW'(det_x);
  assign thr   = MW'(cfg_a[TW-1:0]);
  assign qual  = sharp ? (mag > thr) : (mag < thr);

  assign g_sel = border_in ? border_gain : data_gain;
  assign g_eff = (sharp && g_sel > GCAP) ? GCAP : g_sel;

  assign prod  = XW'(det_x) * $signed({{(XW-GW){1'b0}}, g_eff});
  assign corr  = sharp ? (prod >>> GW) : (prod >>> (GW - 1));
  assign delta = !qual ? '0 : (sharp ? corr : -corr);
  assign sum   = $signed({{(XW-PW){1'b0}}, luma_in}) + delta;

  always_comb begin
    if (sum < 0)         y_next = '0;
    else if (sum > YMAX) y_next = '1;
    else                 y_next = sum[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      luma_out  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= pix_en;
      if (pix_en) luma_out <= y_next;
    end
  end
endmodule

// File: rtl/luma_coring_sharpen_chk.sv
module luma_coring_sharpen_chk #(
  parameter int PW = 8,
  parameter int DW = 9,
  parameter int GW = 4,
  parameter int TW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic [PW-1:0] luma_in,
  input logic [DW-1:0] detail_in,
  input logic          border_in,
  input logic [7:0]    cfg_a,
  input logic [7:0]    cfg_b,
  input logic [GW-1:0] border_gain,
  input logic [GW-1:0] data_gain,
  input logic [PW-1:0] luma_out,
  input logic          out_valid
);
  logic [DW:0] c_mag, c_thr;
  assign c_mag = detail_in[DW-1] ? (DW+1)'(-$signed({detail_in[DW-1], detail_in}))
                                 : (DW+1)'(detail_in);
  assign c_thr = (DW+1)'(cfg_a[TW-1:0]);

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> out_valid);
  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> !out_valid);
  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(luma_out));
  // R1
  tie_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && c_mag == c_thr) |=> luma_out == $past(luma_in));
  // R4
  nonqual_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && (cfg_b[3] ? (c_mag <= c_thr) : (c_mag >= c_thr))) |=> luma_out == $past(luma_in));
  // R5
  zero_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && (border_in ? border_gain : data_gain) == '0) |=> luma_out == $past(luma_in));
endmodule

bind luma_coring_sharpen luma_coring_sharpen_chk #(.PW(PW), .DW(DW), .GW(GW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .luma_in(luma_in), .detail_in(detail_in),
  .border_in(border_in), .cfg_a(cfg_a), .cfg_b(cfg_b), .border_gain(border_gain),
  .data_gain(data_gain), .luma_out(luma_out), .out_valid(out_valid)
);

// File: tb/luma_coring_sharpen_tb.sv
module luma_coring_sharpen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_en = 1'b0;
  logic [7:0] luma_in = '0;
  logic [8:0] detail_in = '0;
  logic       border_in = 1'b0;
  logic [7:0] cfg_a = '0;
  logic [7:0] cfg_b = '0;
  logic [3:0] border_gain = '0;
  logic [3:0] data_gain = '0;
  logic [7:0] luma_out;
  logic       out_valid;
  logic [2:0] flt_sel;
  logic [3:0] blk_offset;
  logic       border_wide, blk_large;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  luma_coring_sharpen u_dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .luma_in(luma_in), .detail_in(detail_in),
    .border_in(border_in), .cfg_a(cfg_a), .cfg_b(cfg_b), .border_gain(border_gain),
    .data_gain(data_gain), .luma_out(luma_out), .out_valid(out_valid), .flt_sel(flt_sel),
    .blk_offset(blk_offset), .border_wide(border_wide), .blk_large(blk_large)
  );

  // {req[3:0], mode, border, thr[5:0], bg[3:0], dg[3:0], luma[7:0], detail[8:0], expected[7:0]}
  localparam int NV = 19;
  localparam logic [44:0] VEC [NV] = '{
    {4'd2, 1'b0, 1'b0, 6'd20, 4'd0, 4'd4, 8'd100,  9'sd10,   8'd95},  // R2 subtract
    {4'd2, 1'b0, 1'b0, 6'd20, 4'd0, 4'd4, 8'd100, -9'sd10,   8'd105}, // R2 negative detail
    {4'd2, 1'b0, 1'b0, 6'd20, 4'd0, 4'd1, 8'd100, -9'sd3,    8'd101}, // R2 floor of -3/8
    {4'd2, 1'b0, 1'b0, 6'd20, 4'd0, 4'd1, 8'd100,  9'sd3,    8'd100}, // R2 floor of 3/8
    {4'd1, 1'b0, 1'b0, 6'd20, 4'd0, 4'd4, 8'd100,  9'sd20,   8'd100}, // R1 tie, noise
    {4'd4, 1'b0, 1'b0, 6'd20, 4'd0, 4'd4, 8'd100,  9'sd30,   8'd100}, // R4 above, noise
    {4'd4, 1'b0, 1'b0, 6'd63, 4'd0, 4'd8, 8'd50,  -9'sd256,  8'd50},  // R4 most negative
    {4'd3, 1'b1, 1'b0, 6'd20, 4'd0, 4'd8, 8'd100,  9'sd40,   8'd120}, // R3 add
    {4'd3, 1'b1, 1'b0, 6'd20, 4'd0, 4'd8, 8'd100, -9'sd40,   8'd80},  // R3 negative
    {4'd3, 1'b1, 1'b0, 6'd20, 4'd0, 4'd15, 8'd100, 9'sd40,   8'd120}, // R3 gain cap
    {4'd1, 1'b1, 1'b0, 6'd20, 4'd0, 4'd8, 8'd100,  9'sd20,   8'd100}, // R1 tie, sharp
    {4'd4, 1'b1, 1'b0, 6'd20, 4'd0, 4'd8, 8'd100,  9'sd10,   8'd100}, // R4 below, sharp
    {4'd5, 1'b1, 1'b1, 6'd20, 4'd4, 4'd8, 8'd100,  9'sd40,   8'd110}, // R5 border gain
    {4'd5, 1'b0, 1'b1, 6'd20, 4'd8, 4'd0, 8'd100,  9'sd10,   8'd90},  // R5 border gain
    {4'd5, 1'b0, 1'b0, 6'd20, 4'd8, 4'd0, 8'd100,  9'sd10,   8'd100}, // R5 data gain zero
    {4'd6, 1'b1, 1'b1, 6'd0,  4'd8, 4'd0, 8'd250,  9'sd100,  8'd255}, // R6 high, border
    {4'd6, 1'b0, 1'b0, 6'd63, 4'd0, 4'd15, 8'd5,   9'sd40,   8'd0},   // R6 low
    {4'd6, 1'b1, 1'b0, 6'd0,  4'd0, 4'd8, 8'd10,  -9'sd200,  8'd0},   // R6 low, sharp
    {4'd6, 1'b0, 1'b1, 6'd63, 4'd8, 4'd0, 8'd250, -9'sd40,   8'd255}  // R6 high, border
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [44:0] v);
    @(negedge clk);
    cfg_b       = {4'h0, v[40], 3'd0};
    border_in   = v[39];
    cfg_a       = {2'b00, v[38:33]};
    border_gain = v[32:29];
    data_gain   = v[28:25];
    luma_in     = v[24:17];
    detail_in   = v[16:8];
    pix_en      = 1'b1;
    @(negedge clk);
    pix_en = 1'b0;
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] held;
    // R8 reset state
    pix_en = 1'b1; luma_in = 8'd77;
    repeat (3) @(negedge clk);
    check(luma_out == 8'd0, "R8 luma_out", luma_out, 0);
    check(out_valid == 1'b0, "R8 out_valid", out_valid, 0);
    pix_en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i]);
      check(out_valid == 1'b1, "R7 valid", out_valid, 1);
      check(luma_out == VEC[i][7:0], $sformatf("R%0d vector %0d", VEC[i][44:41], i),
            luma_out, VEC[i][7:0]);
      @(negedge clk);
      check(out_valid == 1'b0, "R7 pulse length", out_valid, 0);
    end

    // R7 hold while idle, with changing inputs that would otherwise alter the result
    send({4'd2, 1'b0, 1'b0, 6'd20, 4'd0, 4'd4, 8'd100, 9'sd10, 8'd95});
    held = luma_out;
    luma_in = 8'd3; detail_in = 9'sd5; data_gain = 4'd15; cfg_b = 8'h08;
    repeat (4) @(negedge clk);
    check(luma_out == held, "R7 hold", luma_out, held);
    check(out_valid == 1'b0, "R7 idle valid", out_valid, 0);

    // R9 field pass-through
    cfg_a = 8'b1011_0101; cfg_b = 8'hA5;
    #1;
    check(flt_sel == 3'd5, "R9 flt_sel", flt_sel, 5);
    check(blk_offset == 4'hA, "R9 blk_offset", blk_offset, 10);
    check(blk_large == 1'b1, "R9 blk_large", blk_large, 1);
    check(border_wide == 1'b0, "R9 border_wide", border_wide, 0);
    cfg_a = 8'b0100_0000; cfg_b = 8'h32;
    #1;
    check(border_wide == 1'b1, "R9 border_wide", border_wide, 1);
    check(blk_large == 1'b0, "R9 blk_large", blk_large, 0);
    check(flt_sel == 3'd2 && blk_offset == 4'h3, "R9 filter and offset",
          {blk_offset, flt_sel}, {4'h3, 3'd2});

    // R8 reset mid-stream clears the registered output
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(luma_out == 8'd0 && out_valid == 1'b0, "R8 async clear", luma_out, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule